// File: doc/BRIEF.md
# I2S Serial Audio Transmitter with Byte FIFO

This block turns bytes written by a host into a two-channel serial audio stream: a bit clock, a word-select line and a data line. The host pushes bytes one at a time into a 128-byte FIFO. The bytes are moved in groups of four into a 32-bit frame register. The frame is sent MSB first as a left sample followed by a right sample, each 16 bits wide. In mono mode one 32-bit word supplies two frames, and each frame repeats one sample on both channels.

Two control levels drive the block. The clock enable runs the divider chain that makes the bit clock and word select. The transmit enable lets data flow out of the FIFO. Clearing the transmit enable aborts the transfer and discards what is queued, but the clocks keep running if the clock enable stays high. The host refills the FIFO in 64-byte blocks. It is told when to refill by a one-cycle interrupt pulse, raised when half the FIFO has drained and again when all of it has drained.

Top module: `i2s_fifo_tx`

## Requirements
- R1: The FIFO stores 128 bytes. A write strobe adds one byte whether transmission is on or off. A write made while the FIFO holds 128 bytes is dropped, and the dropped byte never appears on the line.
- R2: In stereo mode each group of four bytes forms one frame. The first written byte is the most significant, and the first two bytes make the left sample. Samples go out MSB first. Word select is 0 for left and 1 for right, and each sample's MSB appears one bit clock after the word-select edge that starts it.
- R3: In mono mode each four-byte word fills two frames. The upper 16 bits go out on both channels in the first frame, and the lower 16 bits go out on both channels in the next frame.
- R4: `irq` is a one-cycle pulse that is raised only while transmitting. It fires on each four-byte transfer that brings the total number of bytes consumed to a multiple of 64. Draining 128 bytes therefore gives exactly two pulses.
- R5: `fifoEmpty` is 1 exactly when the FIFO holds no bytes.
- R6: While transmission is enabled, frames follow one another with no host action for as long as a full word is queued. Once the FIFO has no full word, zero samples are sent and the clocks keep running.
- R7: A falling edge on the transmit enable flushes the FIFO, so `fifoEmpty` is 1 on the next cycle. It also clears the frame register, and `sd` is 0 from the next cycle for as long as transmission stays off. Enabling again after a flush sends only zeros.
- R8: With the clock enable at 1, the bit clock and word select run whatever the transmit enable is. Clearing the transmit enable does not reset them.
- R9: With the clock enable at 0, both counters are cleared and stopped. On the next cycle `ws` is 0 and `sck` is at its idle level: 0 when `fallEdge` is 0, and 1 when `fallEdge` is 1.
- R10: The bit clock period is 2·(divCfg+1) clock cycles. Each word-select half lasts slotCfg+1 bit clocks. With `fallEdge`=1 the bit clock is inverted, so data changes on its rising edge and is sampled on its falling edge.
- R11: `divCfg` and `slotCfg` are captured only while the clock enable is 0. Changing them while the clock runs has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Byte write strobe into the FIFO |
| wrData | input | 8 | Byte to write |
| txEnable | input | 1 | Transmit enable; falling edge aborts and flushes |
| cntEnable | input | 1 | Runs the bit-clock and word-select counters |
| monoMode | input | 1 | 1 = one sample duplicated on both channels |
| fallEdge | input | 1 | 1 = bit clock inverted (falling-edge sampling) |
| divCfg | input | 8 | Bit clock half period minus one, in clk cycles |
| slotCfg | input | 6 | Bit clocks per channel slot minus one (at least 15) |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select (0 = left) |
| sd | output | 1 | Serial data |
| irq | output | 1 | Refill pulse at 64-byte drain points |
| fifoEmpty | output | 1 | FIFO holds no bytes |

## Verification
The assertions assume that the host changes `monoMode` and `fallEdge` only while the clock enable is 0. They also assume that `slotCfg` is never below 15, so that a whole sample fits in a slot. Under these assumptions the idle levels and the one-cycle `irq` shape can be checked every cycle. The stimulus sets the configuration and framing inputs only with both enables low, and drives every input on the falling clock edge. Each scenario starts from stopped counters, so the bench's serial decoder always locks to the first word-select edge.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;
  // width of the in-slot bit position counter
  localparam int POS_W = 6;

  typedef struct packed {
    logic             tick;        // bit-clock falling point: data advances
    logic             frameStart;  // last bit of right slot: next frame loads
    logic             flush;       // transmit enable just dropped
    logic             txOn;        // transmit enable level
    logic             chanR;       // current slot is the right channel
    logic [POS_W-1:0] bitPos;      // bit position inside the slot
  } strobe_t;
endpackage

// File: rtl/i2stx_ctrl.sv
module i2stx_ctrl
  import i2stx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEnable,
  input  logic             cntEnable,
  input  logic [DIV_W-1:0] divCfgIn,
  input  logic [POS_W-1:0] slotCfgIn,
  output logic             sckLvl,
  output logic             wsLvl,
  output strobe_t          strb
);
  logic [DIV_W-1:0] divCfg, divCnt;
  logic [POS_W-1:0] slotCfg, pos;
  logic             sckInt, wsReg, txPrev;
  logic             divHit;

  assign divHit = (divCnt == divCfg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCfg  <= '0;
      slotCfg <= '0;
      divCnt  <= '0;
      pos     <= '0;
      sckInt  <= 1'b0;
      wsReg   <= 1'b0;
      txPrev  <= 1'b0;
    end else begin
      txPrev <= txEnable;
      if (!cntEnable) begin
        divCfg  <= divCfgIn;
        slotCfg <= slotCfgIn;
        divCnt  <= '0;
        pos     <= '0;
        sckInt  <= 1'b0;
        wsReg   <= 1'b0;
      end else if (divHit) begin
        divCnt <= '0;
        sckInt <= ~sckInt;
        if (sckInt) begin
          if (pos == slotCfg) begin
            pos   <= '0;
            wsReg <= ~wsReg;
          end else begin
            pos <= pos + 1'b1;
          end
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.tick       = cntEnable & divHit & sckInt;
    strb.frameStart = strb.tick & (pos == slotCfg) & wsReg;
    strb.flush      = txPrev & ~txEnable;
    strb.txOn       = txEnable;
    strb.chanR      = wsReg;
    strb.bitPos     = pos;
  end

  assign sckLvl = sckInt;
  assign wsLvl  = wsReg;
endmodule

// File: rtl/i2stx_datapath.sv
module i2stx_datapath
  import i2stx_pkg::*;
#(
  parameter int FIFO_BYTES = 128,
  parameter int IRQ_BLOCK  = 64,
  parameter int SAMPLE_W   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       monoMode,
  input  strobe_t    strb,
  output logic       sdOut,
  output logic       irqOut,
  output logic       emptyOut
);
  localparam int AW         = $clog2(FIFO_BYTES);
  localparam int BLK_W      = $clog2(IRQ_BLOCK);
  localparam int WORD_W     = 2 * SAMPLE_W;
  localparam int WORD_BYTES = WORD_W / 8;

  logic [7:0]          mem [FIFO_BYTES];
  logic [AW:0]         wrPtr, rdPtr, level, nextRd;
  logic [WORD_W-1:0]   fifoWord, frame;
  logic [SAMPLE_W-1:0] hold, slot, shifted;
  logic                phase, sdReg, irqReg;
  logic                full, wordAvail, wrOk, pop;

  assign level     = wrPtr - rdPtr;
  assign full      = (level == (AW+1)'(FIFO_BYTES));
  assign wordAvail = (level >= (AW+1)'(WORD_BYTES));
  assign wrOk      = wrEn & ~full & ~strb.flush;
  assign nextRd    = rdPtr + (AW+1)'(WORD_BYTES);
  assign pop       = strb.frameStart & strb.txOn & wordAvail & ~(monoMode & phase);

  // gather one word starting at the read pointer, first byte most significant
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_rd
    logic [AW-1:0] rdAddr;
    assign rdAddr = rdPtr[AW-1:0] + AW'(g);
    assign fifoWord[WORD_W-1-8*g -: 8] = mem[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (wrOk) mem[wrPtr[AW-1:0]] <= wrData;
  end

  // bit selection: shifting past the sample width yields zero padding
  always_comb begin
    slot    = strb.chanR ? frame[SAMPLE_W-1:0] : frame[WORD_W-1:SAMPLE_W];
    shifted = slot << strb.bitPos;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.flush) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      frame  <= '0;
      hold   <= '0;
      phase  <= 1'b0;
      sdReg  <= 1'b0;
      irqReg <= 1'b0;
    end else begin
      irqReg <= 1'b0;
      if (wrOk) wrPtr <= wrPtr + 1'b1;
      if (pop) begin
        rdPtr  <= nextRd;
        irqReg <= (nextRd[BLK_W-1:0] == '0);
      end
      if (!strb.txOn) begin
        frame <= '0;
        phase <= 1'b0;
        sdReg <= 1'b0;
      end else begin
        if (strb.tick) sdReg <= shifted[SAMPLE_W-1];
        if (strb.frameStart) begin
          if (!monoMode) begin
            frame <= wordAvail ? fifoWord : '0;
          end else if (!phase) begin
            if (wordAvail) begin
              frame <= {fifoWord[WORD_W-1:SAMPLE_W], fifoWord[WORD_W-1:SAMPLE_W]};
              hold  <= fifoWord[SAMPLE_W-1:0];
              phase <= 1'b1;
            end else begin
              frame <= '0;
            end
          end else begin
            frame <= {hold, hold};
            phase <= 1'b0;
          end
        end
      end
    end
  end

  assign sdOut    = sdReg;
  assign irqOut   = irqReg;
  assign emptyOut = (level == '0);
endmodule

// File: rtl/i2s_fifo_tx.sv
module i2s_fifo_tx
  import i2stx_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int FIFO_BYTES = 128,
  parameter int IRQ_BLOCK  = 64,
  parameter int SAMPLE_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  input  logic             txEnable,
  input  logic             cntEnable,
  input  logic             monoMode,
  input  logic             fallEdge,
  input  logic [DIV_W-1:0] divCfg,
  input  logic [POS_W-1:0] slotCfg,
  output logic             sck,
  output logic             ws,
  output logic             sd,
  output logic             irq,
  output logic             fifoEmpty
);
  strobe_t strb;
  logic    sckLvl;

  i2stx_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .txEnable  (txEnable),
    .cntEnable (cntEnable),
    .divCfgIn  (divCfg),
    .slotCfgIn (slotCfg),
    .sckLvl    (sckLvl),
    .wsLvl     (ws),
    .strb      (strb)
  );

  i2stx_datapath #(
    .FIFO_BYTES (FIFO_BYTES),
    .IRQ_BLOCK  (IRQ_BLOCK),
    .SAMPLE_W   (SAMPLE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .monoMode (monoMode),
    .strb     (strb),
    .sdOut    (sd),
    .irqOut   (irq),
    .emptyOut (fifoEmpty)
  );

  assign sck = sckLvl ^ fallEdge;
endmodule

// File: rtl/i2stx_chk.sv
module i2stx_chk (
  input logic clk,
  input logic rstN,
  input logic txEnable,
  input logic cntEnable,
  input logic fallEdge,
  input logic sck,
  input logic ws,
  input logic sd,
  input logic irq,
  input logic fifoEmpty
);
  // R9
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cntEnable |=> (!ws && sck == fallEdge));

  // R7
  sd_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> !sd);

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEnable) |=> fifoEmpty);

  // R4
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R4
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> !irq);
endmodule

bind i2s_fifo_tx i2stx_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .txEnable  (txEnable),
  .cntEnable (cntEnable),
  .fallEdge  (fallEdge),
  .sck       (sck),
  .ws        (ws),
  .sd        (sd),
  .irq       (irq),
  .fifoEmpty (fifoEmpty)
);

// File: tb/sim_i2s_fifo_tx.sv
`timescale 1ns/1ps
module sim_i2s_fifo_tx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic txEnable = 1'b0, cntEnable = 1'b0, monoMode = 1'b0, fallEdge = 1'b0;
  logic [7:0] divCfg = '0;
  logic [5:0] slotCfg = 6'd15;
  logic sck, ws, sd, irq, fifoEmpty;

  int testCnt = 0;
  int failCnt = 0;

  always #2.5 clk = ~clk;

  i2s_fifo_tx u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .txEnable(txEnable), .cntEnable(cntEnable), .monoMode(monoMode),
    .fallEdge(fallEdge), .divCfg(divCfg), .slotCfg(slotCfg),
    .sck(sck), .ws(ws), .sd(sd), .irq(irq), .fifoEmpty(fifoEmpty)
  );

  // ---------------- serial receiver model ----------------
  logic        capEn = 1'b0;
  logic [15:0] lArr [0:63];
  logic [15:0] rArr [0:63];
  int          lCnt, rCnt, nBits, irqCnt;
  logic [15:0] acc;
  logic        prevWs, prevSck, active, chan, seenL;

  always @(posedge clk) begin
    #1;
    if (!capEn) begin
      lCnt = 0; rCnt = 0; nBits = 0; irqCnt = 0; acc = '0;
      active = 1'b0; seenL = 1'b0; chan = 1'b0;
      prevWs = ws;
    end else begin
      if (irq) irqCnt++;
      if (sck != prevSck && sck == !fallEdge) begin
        if (active) begin
          acc = {acc[14:0], sd};
          nBits++;
          if (nBits == 16) begin
            active = 1'b0;
            if (!chan) begin
              seenL = 1'b1;
              if (lCnt < 64) begin lArr[lCnt] = acc; lCnt++; end
            end else if (seenL && rCnt < 64) begin
              rArr[rCnt] = acc; rCnt++;
            end
          end
        end
        if (ws != prevWs) begin
          active = 1'b1; chan = ws; nBits = 0;
        end
        prevWs = ws;
      end
    end
    prevSck = sck;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 7 + seed) & 255);
  endfunction

  task automatic writeBytes(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      wrEn = 1'b1; wrData = pat(i, seed);
      @(negedge clk);
    end
    wrEn = 1'b0;
  endtask

  task automatic waitL(input int n);
    for (int i = 0; i < 40000 && lCnt < n; i++) @(negedge clk);
  endtask

  task automatic restartCapture();
    capEn = 1'b0;
    repeat (2) @(negedge clk);
    capEn = 1'b1;
  endtask

  task automatic stopAll();
    txEnable = 1'b0; cntEnable = 1'b0;
    repeat (2) @(negedge clk);
    capEn = 1'b0;
    monoMode = 1'b0; fallEdge = 1'b0;
    @(negedge clk);
  endtask

  task automatic measureSck(output int period);
    period = 0;
    for (int i = 0; i < 1000 && sck !== 1'b0; i++) @(negedge clk);
    for (int i = 0; i < 1000 && sck !== 1'b1; i++) @(negedge clk);
    for (int i = 0; i < 1000 && sck !== 1'b0; i++) begin @(negedge clk); period++; end
    for (int i = 0; i < 1000 && sck !== 1'b1; i++) begin @(negedge clk); period++; end
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    chk("R9 reset sck idle", 32'(sck), 0);
    chk("R9 reset ws idle", 32'(ws), 0);
    chk("R7 reset sd low", 32'(sd), 0);
    chk("R5 reset empty", 32'(fifoEmpty), 1);
    chk("R4 reset irq low", 32'(irq), 0);
  endtask

  task automatic testStereo();
    writeBytes(130, 3);
    chk("R5 not empty after fill", 32'(fifoEmpty), 0);
    restartCapture();
    cntEnable = 1'b1; txEnable = 1'b1;
    waitL(34);
    for (int k = 0; k < 32; k++) begin
      chk("R2 left sample", 32'(lArr[k]), 32'({pat(4*k, 3), pat(4*k+1, 3)}));
      chk("R2 right sample", 32'(rArr[k]), 32'({pat(4*k+2, 3), pat(4*k+3, 3)}));
    end
    chk("R1 dropped bytes absent L", 32'(lArr[32]), 0);
    chk("R1 dropped bytes absent R", 32'(rArr[32]), 0);
    chk("R6 zero fill after drain", 32'(lArr[33]), 0);
    chk("R4 two pulses for 128 bytes", 32'(irqCnt), 2);
    chk("R5 empty after drain", 32'(fifoEmpty), 1);
    stopAll();
  endtask

  task automatic testMono();
    monoMode = 1'b1; fallEdge = 1'b1;
    @(negedge clk);
    chk("R9 idle high in falling mode", 32'(sck), 1);
    writeBytes(64, 11);
    restartCapture();
    cntEnable = 1'b1; txEnable = 1'b1;
    waitL(33);
    for (int k = 0; k < 16; k++) begin
      chk("R3 upper on left", 32'(lArr[2*k]), 32'({pat(4*k, 11), pat(4*k+1, 11)}));
      chk("R3 upper on right", 32'(rArr[2*k]), 32'({pat(4*k, 11), pat(4*k+1, 11)}));
      chk("R3 lower on left", 32'(lArr[2*k+1]), 32'({pat(4*k+2, 11), pat(4*k+3, 11)}));
      chk("R3 lower on right", 32'(rArr[2*k+1]), 32'({pat(4*k+2, 11), pat(4*k+3, 11)}));
    end
    chk("R10 falling-edge mode zero after data", 32'(lArr[32]), 0);
    chk("R4 one pulse for 64 bytes", 32'(irqCnt), 1);
    stopAll();
  endtask

  task automatic testAbort();
    int toggles;
    logic lastSck;
    writeBytes(64, 5);
    restartCapture();
    cntEnable = 1'b1; txEnable = 1'b1;
    waitL(4);
    chk("R6 streaming before abort", 32'(lArr[1]), 32'({pat(4, 5), pat(5, 5)}));
    txEnable = 1'b0;
    @(negedge clk);
    chk("R7 flushed next cycle", 32'(fifoEmpty), 1);
    chk("R7 sd low next cycle", 32'(sd), 0);
    toggles = 0; lastSck = sck;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (sd !== 1'b0) begin
        chk("R7 sd stays low while off", 32'(sd), 0);
        break;
      end
      if (sck != lastSck) toggles++;
      lastSck = sck;
    end
    chk("R8 clock keeps running after tx off", 32'(toggles > 50), 1);
    restartCapture();
    txEnable = 1'b1;
    waitL(3);
    chk("R7 resume sends zeros L", 32'(lArr[0] | lArr[1] | lArr[2]), 0);
    chk("R7 resume sends zeros R", 32'(rArr[0] | rArr[1]), 0);
    chk("R7 still empty after resume", 32'(fifoEmpty), 1);
    cntEnable = 1'b0; txEnable = 1'b0;
    @(negedge clk);
    chk("R9 ws idle after stop", 32'(ws), 0);
    chk("R9 sck idle after stop", 32'(sck), 0);
    stopAll();
  endtask

  task automatic testConfig();
    int per;
    int wsHigh;
    divCfg = 8'd2; slotCfg = 6'd15;
    @(negedge clk);
    cntEnable = 1'b1;
    measureSck(per);
    chk("R10 period for divide 2", 32'(per), 6);
    for (int i = 0; i < 2000 && ws !== 1'b0; i++) @(negedge clk);
    for (int i = 0; i < 2000 && ws !== 1'b1; i++) @(negedge clk);
    wsHigh = 0;
    for (int i = 0; i < 2000 && ws === 1'b1; i++) begin @(negedge clk); wsHigh++; end
    chk("R10 word-select half length", 32'(wsHigh), 96);
    divCfg = 8'd0;
    repeat (3) @(negedge clk);
    measureSck(per);
    chk("R11 divide unchanged while running", 32'(per), 6);
    cntEnable = 1'b0;
    @(negedge clk);
    cntEnable = 1'b1;
    measureSck(per);
    chk("R11 new divide taken while stopped", 32'(per), 2);
    stopAll();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStereo();
    testMono();
    testAbort();
    testConfig();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule